// File: doc/BRIEF.md
# Receive Ring Page Manager

This block stores frames arriving from a MAC-side byte stream into a circular buffer. The buffer lives in local memory and is cut into 256-byte pages. Four page registers set the ring and track it: first ring page, stop page (exclusive), current write page and boundary. Every frame body begins four bytes into the current page. When a good frame ends, the block fills those four bytes with a header: status, next-frame page and a 16-bit length. It then moves the current page past the last byte written.

The host has two ports. It reads stored frames through a byte-wide memory read port. It frees pages by writing the boundary register, which points one page behind the next frame the host will read. The block drops a frame when storing it would move the current page onto the boundary, and raises an overwrite warning. It discards a frame that ends with an error flag and leaves the ring untouched. Two sticky status flags report a frame received intact and the overwrite warning. `ringEmpty` reports whether any unread frame is left.

Top module: `rx_ring_pager`

## Requirements
- R1: Byte address is page × 256 + offset. The first byte of a frame is stored at offset 4 of the current page, and each later byte at the next address.
- R2: A good frame's header sits at offsets 0..3 of its first page. Offset 0 holds status 0x01 (bit 0 = received intact). Offset 1 holds the next-frame page. Offsets 2 and 3 hold the byte count, low byte first. The count covers every stream byte, including the 4 check-sequence bytes.
- R3: When a good frame ends, the current page becomes the page after the one holding the last byte, and `rxOkFlag` is set.
- R4: The page after stop−1 is the start page. A frame body that runs off the end of page stop−1 continues at offset 0 of the start page.
- R5: `ringEmpty` is 1 exactly when boundary+1 (wrapped to the start page at the stop page) equals the current page.
- R6: After reset, start = 1, stop = 8, current page = start, boundary = stop−1, and both flags are 0.
- R7: A frame is dropped if either of these would make the current page equal the boundary: crossing into a new page, or finishing the frame. On a drop, `ovwFlag` is set, the current page is unchanged and `rxOkFlag` is not set. Bytes are ignored until end of frame, and the next frame is received normally.
- R8: A frame whose end-of-frame byte carries `rxErr` is discarded. The current page and both flags are unchanged, even when the frame would also have overflowed.
- R9: Register map. With `regPage`=0: address 0 = start page, 1 = stop page, 2 = boundary. With `regPage`=1: address 0 = current page. Each of these can be written and read back; unmapped reads return 0.
- R10: `intAck` bit 0 clears `rxOkFlag` and bit 1 clears `ovwFlag`.
- R11: `memRdData` returns the byte at `memRdAddr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Stream byte valid |
| rxSof | input | 1 | First byte of frame |
| rxEof | input | 1 | Last byte of frame |
| rxErr | input | 1 | Frame bad, sampled with rxEof |
| rxData | input | 8 | Stream byte |
| regWr | input | 1 | Register write strobe |
| regPage | input | 1 | Register page select |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| memRdAddr | input | 11 | Host memory read address |
| memRdData | output | 8 | Host memory read data, one cycle later |
| intAck | input | 2 | Flag clear, bit 0 intact, bit 1 overwrite |
| rxOkFlag | output | 1 | Sticky: frame received intact |
| ovwFlag | output | 1 | Sticky: overwrite warning |
| ringEmpty | output | 1 | No unread frame in ring |

## Verification
Suppose the write page or write offset goes wrong. Then the header's next-page byte and the current-page register read back wrong right after that frame ends. The scoreboard's memory readback of that frame also mismatches at the first misplaced byte. A wrong wrap or overflow decision shows within one frame: the current page ends up on the boundary, or `ovwFlag` takes the wrong value. An error frame that leaks through moves the current page, which the register read right after end-of-frame catches.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int HDR_BYTES = 4;
  localparam logic [7:0] STAT_INTACT = 8'h01;

  typedef struct packed {
    logic start;     // first byte of frame: latch current page
    logic wrByte;    // store incoming byte
    logic advPage;   // write offset wraps, go to following page
    logic commit;    // good end: write header, move current page
    logic overflow;  // drop frame, raise overwrite warning
    logic discard;   // error end: leave ring untouched
  } rxStrobe_t;
endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxSof,
  input  logic       rxEof,
  input  logic       rxErr,
  input  logic       wrOffLast,
  input  logic       wrNextIsBnd,
  input  logic       curNextIsBnd,
  output rxStrobe_t  stb
);
  typedef enum logic [1:0] {S_IDLE, S_RECV, S_DROP} state_t;
  state_t state, stateNxt;
  logic offLast, hitBnd;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    offLast  = rxSof ? 1'b0 : wrOffLast;
    hitBnd   = rxSof ? curNextIsBnd : wrNextIsBnd;
    if (rxValid) begin
      if (rxSof || state == S_RECV) begin
        stb.start  = rxSof;
        stb.wrByte = 1'b1;
        if (rxEof && rxErr) begin
          stb.discard = 1'b1;
          stateNxt    = S_IDLE;
        end else if ((rxEof || offLast) && hitBnd) begin
          stb.overflow = 1'b1;
          stateNxt     = rxEof ? S_IDLE : S_DROP;
        end else if (rxEof) begin
          stb.commit = 1'b1;
          stateNxt   = S_IDLE;
        end else begin
          stb.advPage = offLast;
          stateNxt    = S_RECV;
        end
      end else if (state == S_DROP && rxEof) begin
        stateNxt = S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.commit, stb.overflow, stb.discard})); // R3

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DROP && rxValid && !rxSof) |-> !stb.wrByte); // R7
endmodule

// File: rtl/rx_ring_dp.sv
module rx_ring_dp
  import rx_ring_pkg::*;
#(
  parameter int PG_W      = 8,
  parameter int MEM_PAGES = 8,
  parameter int RST_START = 1,
  parameter int RST_STOP  = 8,
  parameter int LEN_W     = 16,
  localparam int MEM_PG_W = $clog2(MEM_PAGES),
  localparam int MEM_AW   = MEM_PG_W + 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic [7:0]        rxData,
  input  logic              regWr,
  input  logic              regPage,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic [MEM_AW-1:0] memRdAddr,
  output logic [7:0]        memRdData,
  input  logic [1:0]        intAck,
  output logic              rxOkFlag,
  output logic              ovwFlag,
  output logic              ringEmpty,
  output logic              wrOffLast,
  output logic              wrNextIsBnd,
  output logic              curNextIsBnd
);
  localparam int DEPTH = MEM_PAGES * 256;

  logic [PG_W-1:0]  pStart, pStop, curPg, bndPg, wrPg, startPg;
  logic [7:0]       wrOff;
  logic [LEN_W-1:0] byteCnt;
  logic [7:0]       mem [DEPTH];

  logic [PG_W-1:0]  effPg, effStart, followPg;
  logic [7:0]       effOff;
  logic [LEN_W-1:0] effCnt;
  logic [7:0]       hdr [HDR_BYTES];
  logic wrStartReg, wrStopReg, wrBndReg, wrCurReg;

  function automatic logic [PG_W-1:0] nextPg(input logic [PG_W-1:0] p,
                                             input logic [PG_W-1:0] st,
                                             input logic [PG_W-1:0] sp);
    logic [PG_W-1:0] q;
    q = p + 1'b1;
    return (q == sp) ? st : q;
  endfunction

  assign wrStartReg = regWr && !regPage && regAddr == 2'd0;
  assign wrStopReg  = regWr && !regPage && regAddr == 2'd1;
  assign wrBndReg   = regWr && !regPage && regAddr == 2'd2;
  assign wrCurReg   = regWr &&  regPage && regAddr == 2'd0;

  always_comb begin
    effPg    = stb.start ? curPg : wrPg;
    effOff   = stb.start ? 8'(HDR_BYTES) : wrOff;
    effStart = stb.start ? curPg : startPg;
    effCnt   = stb.start ? LEN_W'(1) : byteCnt + 1'b1;
    followPg = nextPg(effPg, pStart, pStop);
    hdr[0]   = STAT_INTACT;
    hdr[1]   = 8'(followPg);
    hdr[2]   = effCnt[7:0];
    hdr[3]   = effCnt[15:8];
  end

  assign wrOffLast    = (wrOff == 8'hFF);
  assign wrNextIsBnd  = (nextPg(wrPg, pStart, pStop) == bndPg);
  assign curNextIsBnd = (nextPg(curPg, pStart, pStop) == bndPg);
  assign ringEmpty    = (nextPg(bndPg, pStart, pStop) == curPg);

  always_comb begin
    regRdata = 8'h00;
    if (!regPage) begin
      case (regAddr)
        2'd0:    regRdata = 8'(pStart);
        2'd1:    regRdata = 8'(pStop);
        2'd2:    regRdata = 8'(bndPg);
        default: regRdata = 8'h00;
      endcase
    end else if (regAddr == 2'd0) begin
      regRdata = 8'(curPg);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pStart   <= PG_W'(RST_START);
      pStop    <= PG_W'(RST_STOP);
      curPg    <= PG_W'(RST_START);
      bndPg    <= PG_W'(RST_STOP - 1);
      wrPg     <= '0;
      startPg  <= '0;
      wrOff    <= '0;
      byteCnt  <= '0;
      rxOkFlag <= 1'b0;
      ovwFlag  <= 1'b0;
    end else begin
      if (wrStartReg) pStart <= PG_W'(regWdata);
      if (wrStopReg)  pStop  <= PG_W'(regWdata);
      if (wrBndReg)   bndPg  <= PG_W'(regWdata);
      if (stb.wrByte) begin
        wrOff   <= effOff + 8'd1;
        byteCnt <= effCnt;
        wrPg    <= stb.advPage ? followPg : effPg;
        startPg <= effStart;
      end
      if (stb.commit)    curPg <= followPg;
      else if (wrCurReg) curPg <= PG_W'(regWdata);
      rxOkFlag <= stb.commit   | (rxOkFlag & ~intAck[0]);
      ovwFlag  <= stb.overflow | (ovwFlag  & ~intAck[1]);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrByte) mem[{effPg[MEM_PG_W-1:0], effOff}] <= rxData;
    if (stb.commit) begin
      for (int i = 0; i < HDR_BYTES; i++)
        mem[{effStart[MEM_PG_W-1:0], 8'(i)}] <= hdr[i];
    end
    memRdData <= mem[memRdAddr];
  end

  AST_OVF_KEEPS_CUR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.overflow && !wrCurReg) |=> (curPg == $past(curPg))); // R7

  AST_ERR_KEEPS_CUR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.discard && !wrCurReg) |=> (curPg == $past(curPg))); // R8

  AST_COMMIT_SETS_OK: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> rxOkFlag); // R3

  AST_HDR_APART: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && stb.wrByte) |->
      ({effPg, effOff[7:2]} != {effStart, 6'd0})); // R2
endmodule

// File: rtl/rx_ring_pager.sv
module rx_ring_pager
  import rx_ring_pkg::*;
#(
  parameter int PG_W      = 8,
  parameter int MEM_PAGES = 8,
  parameter int RST_START = 1,
  parameter int RST_STOP  = 8,
  parameter int LEN_W     = 16,
  localparam int MEM_AW   = $clog2(MEM_PAGES) + 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic              rxSof,
  input  logic              rxEof,
  input  logic              rxErr,
  input  logic [7:0]        rxData,
  input  logic              regWr,
  input  logic              regPage,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic [MEM_AW-1:0] memRdAddr,
  output logic [7:0]        memRdData,
  input  logic [1:0]        intAck,
  output logic              rxOkFlag,
  output logic              ovwFlag,
  output logic              ringEmpty
);
  rxStrobe_t stb;
  logic wrOffLast, wrNextIsBnd, curNextIsBnd;

  rx_ring_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof),
    .rxEof(rxEof), .rxErr(rxErr), .wrOffLast(wrOffLast),
    .wrNextIsBnd(wrNextIsBnd), .curNextIsBnd(curNextIsBnd), .stb(stb)
  );

  rx_ring_dp #(
    .PG_W(PG_W), .MEM_PAGES(MEM_PAGES), .RST_START(RST_START),
    .RST_STOP(RST_STOP), .LEN_W(LEN_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxData(rxData),
    .regWr(regWr), .regPage(regPage), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .intAck(intAck),
    .rxOkFlag(rxOkFlag), .ovwFlag(ovwFlag), .ringEmpty(ringEmpty),
    .wrOffLast(wrOffLast), .wrNextIsBnd(wrNextIsBnd),
    .curNextIsBnd(curNextIsBnd)
  );
endmodule

// File: tb/rx_ring_pager_test.sv
`timescale 1ns/1ps
module rx_ring_pager_test;
  logic clk = 0, rstN = 0;
  logic rxValid = 0, rxSof = 0, rxEof = 0, rxErr = 0;
  logic [7:0] rxData = 0;
  logic regWr = 0, regPage = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWdata = 0, regRdata, memRdData;
  logic [10:0] memRdAddr = 0;
  logic [1:0] intAck = 0;
  logic rxOkFlag, ovwFlag, ringEmpty;

  rx_ring_pager uut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int mCur = 1, mBnd = 7, mStart = 1, mStop = 8;
  bit mOk = 0, mOvw = 0;

  typedef struct { int addr; int data; string req; } sbItem_t;
  sbItem_t sbq[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nextP(input int p);
    return (p + 1 == mStop) ? mStart : p + 1;
  endfunction

  task automatic readReg(input bit pg, input int a, output int v);
    @(negedge clk); regPage = pg; regAddr = 2'(a); #1 v = regRdata;
  endtask

  task automatic writeReg(input bit pg, input int a, input int v);
    @(negedge clk); regPage = pg; regAddr = 2'(a); regWdata = 8'(v); regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  task automatic ack(input int m);
    @(negedge clk); intAck = 2'(m);
    @(negedge clk); intAck = 0;
    if (m[0]) mOk = 0;
    if (m[1]) mOvw = 0;
  endtask

  // monitor: pops expected memory bytes and compares readback (R11 latency)
  task automatic drain();
    while (sbq.size() > 0) begin
      sbItem_t e = sbq.pop_front();
      @(negedge clk); memRdAddr = 11'(e.addr);
      @(negedge clk);
      chk(e.req, $sformatf("mem[%0d]", e.addr), int'(memRdData), e.data);
    end
  endtask

  task automatic checkState(input string req);
    int v;
    readReg(1, 0, v); chk(req, "current page", v, mCur);
    chk(req, "rxOkFlag", int'(rxOkFlag), int'(mOk));
    chk(req, "ovwFlag", int'(ovwFlag), int'(mOvw));
    chk("R5", "ringEmpty", int'(ringEmpty), int'(nextP(mBnd) == mCur));
  endtask

  // driver: streams a frame and pushes expected bytes for good frames
  task automatic sendFrame(input int len, input int seed, input bit err, input string req);
    int p = mCur, o = 4, startP = mCur, newCur = 0;
    bit drop = 0;
    sbItem_t tmp[$];
    for (int k = 0; k < len; k++) begin
      int d = (seed + k * 7) & 255;
      if (!drop) tmp.push_back('{p * 256 + o, d, "R1"});
      @(negedge clk);
      rxValid = 1; rxData = 8'(d); rxSof = (k == 0); rxEof = (k == len - 1);
      rxErr = err && (k == len - 1);
      if (!drop) begin
        o++;
        if (o == 256) begin
          p = nextP(p); o = 0;
          if (k != len - 1 && p == mBnd && !err) drop = 1;
          if (k != len - 1 && p == mBnd && err) drop = 1;
        end
      end
    end
    @(negedge clk); rxValid = 0; rxSof = 0; rxEof = 0; rxErr = 0;
    if (!drop && !err) begin
      newCur = (o == 0) ? p : nextP(p);
      if (newCur == mBnd) drop = 1;
    end
    if (drop) mOvw = 1;
    else if (!err) begin
      sbq.push_back('{startP * 256 + 0, 1, "R2"});
      sbq.push_back('{startP * 256 + 1, newCur, "R2"});
      sbq.push_back('{startP * 256 + 2, len & 255, "R2"});
      sbq.push_back('{startP * 256 + 3, len >> 8, "R2"});
      foreach (tmp[i]) sbq.push_back(tmp[i]);
      mCur = newCur; mOk = 1;
    end
    checkState(req);
    drain();
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R6 reset state
    readReg(0, 0, v); chk("R6", "start", v, 1);
    readReg(0, 1, v); chk("R6", "stop", v, 8);
    readReg(0, 2, v); chk("R6", "boundary", v, 7);
    checkState("R6");
    // R1 R2 R3 short frame
    sendFrame(60, 1, 0, "R3");
    chk("R5", "not empty", int'(ringEmpty), 0);
    ack(1); checkState("R10");
    sendFrame(300, 9, 0, "R3");                 // crosses a page
    ack(1);
    sendFrame(100, 3, 1, "R8");                 // error frame discarded
    // R9 register map
    writeReg(0, 2, 3); mBnd = 3;
    readReg(0, 2, v); chk("R9", "boundary readback", v, 3);
    readReg(0, 0, v); chk("R9", "page0 addr0 is start", v, 1);
    readReg(1, 1, v); chk("R9", "unmapped read", v, 0);
    sendFrame(1100, 5, 0, "R4");                // wraps stop-1 -> start
    chk("R4", "wrapped current page", mCur, 2);
    ack(1);
    sendFrame(20, 11, 0, "R7");                 // end lands on boundary
    chk("R7", "model overflow", int'(mOvw), 1);
    ack(2); checkState("R10");
    sendFrame(20, 13, 1, "R8");                 // error wins over overflow
    writeReg(0, 2, 1); mBnd = 1;
    checkState("R5");
    sendFrame(600, 17, 0, "R3");
    ack(1);
    sendFrame(1000, 19, 0, "R7");               // overflow mid-frame
    sendFrame(10, 23, 0, "R7");                 // recovers afterwards
    writeReg(1, 0, 4); mCur = 4;
    readReg(1, 0, v); chk("R9", "current page write", v, 4);
    readReg(0, 0, v); chk("R9", "start untouched", v, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule